// File: doc/BRIEF.md
# Peripheral Compartment Access Filter

This block holds the access-control configuration for a set of peripheral slots and answers, in the same cycle, whether a given requester may touch a given slot. Each slot carries a compartment-ID filter word and a hardware semaphore. Two packed bit vectors sit beside the slots: one marks slots as secure-only and one marks them as privileged-only. A 32-bit register bus writes this state and reads it back. The bus carries the writer's compartment ID, which the semaphore logic uses to record or check ownership.

The check port takes a slot index, a compartment ID, and secure and privileged attributes, and returns a combinational grant. The ID check works in one of three ways. In semaphore mode, only the current holder passes, and the holder must be on the slot's whitelist; the static owner field is ignored. With plain filtering, the requester's ID must equal the static owner field, unless that field is 0. With filtering off, every ID passes. The secure and privileged vectors then deny non-secure or unprivileged requesters. An index past the slot count is always refused.

Top module: `periph_access_filter`

## Requirements
- R1: The configuration word of slot n is at byte address 0x100+8n. Bit 0 is filter enable. Bit 1 is semaphore enable. Bits 6:4 are the static compartment ID. Bits 23:16 are the whitelist, where bit 16+c allows compartment c. All other bits read 0.
- R2: The secure bit of slot n is bit n%32 of the word at 0x10+4*(n/32). The privileged bit of slot n is at the same bit position of the word at 0x30+4*(n/32). Bits of slots that do not exist read 0, and so do words past the last slot.
- R3: The word at 0xFEC reads {subregion count[31:24], master count[23:16], slot count[15:0]}. Writes to it are ignored.
- R4: The semaphore of slot n is at 0x104+8n. When the semaphore is free, semaphore mode is enabled and the writer's compartment is whitelisted, writing 1 in bit 0 takes it. Readback then shows bit 0 set and the owner ID in bits 6:4.
- R5: Each of the following writes leaves the semaphore unchanged: a take from a compartment that is not whitelisted, a take while semaphore mode is disabled, and any write with bit 0 clear.
- R6: A write of 1 in bit 0 from the owner frees the semaphore, and readback is then 0. The same write from any other compartment leaves owner and state unchanged. After a release, another whitelisted compartment may take the semaphore.
- R7: When filter enable and semaphore enable are both set, only the current semaphore holder passes the ID check, whatever the static ID is.
- R8: When filter enable is clear, or the static ID is 0 and semaphore mode is off, every compartment ID passes the ID check.
- R9: When filtering is on, semaphore mode is off and the static ID is non-zero, only that ID passes.
- R10: A set secure bit denies requests whose secure attribute is low. A set privileged bit denies requests whose privileged attribute is low.
- R11: A slot index equal to or above the slot count is always denied.
- R12: After reset, all configuration is zero, every semaphore is free, and every in-range request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | Write when high, read when low |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_cid_i | input | 3 | Compartment ID of the bus writer |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| chk_idx_i | input | IDX_W | Slot index to check |
| chk_cid_i | input | 3 | Requester compartment ID |
| chk_sec_i | input | 1 | Requester secure attribute |
| chk_priv_i | input | 1 | Requester privileged attribute |
| grant_o | output | 1 | Access granted, combinational |

## Verification
The semaphore assertions assume that each bus write lands on a single, word-aligned address. They also assume that bus_cid_i is stable for the cycle of the write. The bench drives every write for exactly one cycle, set up at the falling edge and held through the rising edge, with word-aligned addresses only. The grant assertions treat the check port as free-running. Any index, including ones past the slot count, is legal there, so the sweep covers indices past the end as well.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  localparam int CID_W = 3;
  localparam int NUM_CID = 1 << CID_W;

  typedef struct packed {
    logic [NUM_CID-1:0] wl;
    logic [CID_W-1:0]   scid;
    logic               sem_en;
    logic               fen;
  } slot_cfg_t;

  function automatic logic [31:0] pack_cfg(slot_cfg_t c);
    return {8'h00, c.wl, 9'h000, c.scid, 2'b00, c.sem_en, c.fen};
  endfunction

  function automatic slot_cfg_t unpack_cfg(logic [31:0] w);
    slot_cfg_t c;
    c.fen    = w[0];
    c.sem_en = w[1];
    c.scid   = w[6:4];
    c.wl     = w[23:16];
    return c;
  endfunction

  function automatic logic [31:0] pack_sem(logic taken, logic [CID_W-1:0] owner);
    return {25'h0, owner, 3'b000, taken};
  endfunction
endpackage

// File: rtl/pcf_slot.sv
module pcf_slot
  import pcf_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic             sem_we_i,
  input  logic [31:0]      wdata_i,
  input  logic [CID_W-1:0] wr_cid_i,
  output slot_cfg_t        cfg_o,
  output logic             taken_o,
  output logic [CID_W-1:0] owner_o
);
  slot_cfg_t        cfg_q;
  logic             taken_q;
  logic [CID_W-1:0] owner_q;
  logic             may_take, is_owner;

  assign may_take = !taken_q && cfg_q.sem_en && cfg_q.wl[wr_cid_i];
  assign is_owner = taken_q && (owner_q == wr_cid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      taken_q <= 1'b0;
      owner_q <= '0;
    end else begin
      if (cfg_we_i) cfg_q <= unpack_cfg(wdata_i);
      if (sem_we_i && wdata_i[0]) begin
        if (may_take) begin
          taken_q <= 1'b1;
          owner_q <= wr_cid_i;
        end else if (is_owner) begin
          taken_q <= 1'b0;
          owner_q <= '0;
        end
      end
    end
  end

  assign cfg_o   = cfg_q;
  assign taken_o = taken_q;
  assign owner_o = owner_q;

  // R5
  sem_blocked_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sem_we_i && !taken_q && !(cfg_q.sem_en && cfg_q.wl[wr_cid_i])) |=> !taken_q);
  // R6
  sem_foreign_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sem_we_i && taken_q && owner_q != wr_cid_i) |=> (taken_q && $stable(owner_q)));
  // R4
  sem_take_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(taken_q) |-> $past(sem_we_i && wdata_i[0]));
endmodule

// File: rtl/pcf_attr_bank.sv
module pcf_attr_bank #(
  parameter int NUM_SLOTS = 128,
  parameter int WSEL_W    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [WSEL_W-1:0]    word_i,
  input  logic [31:0]          wdata_i,
  output logic [NUM_SLOTS-1:0] vec_o,
  output logic [31:0]          rword_o
);
  localparam int NW = (NUM_SLOTS + 31) / 32;

  logic [NUM_SLOTS-1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bits_q <= '0;
    end else if (we_i && int'(word_i) < NW) begin
      for (int s = 0; s < NUM_SLOTS; s++)
        if (s / 32 == int'(word_i)) bits_q[s] <= wdata_i[s % 32];
    end
  end

  always_comb begin
    rword_o = '0;
    for (int b = 0; b < 32; b++)
      if (int'(word_i) * 32 + b < NUM_SLOTS) rword_o[b] = bits_q[int'(word_i) * 32 + b];
  end

  assign vec_o = bits_q;
endmodule

// File: rtl/pcf_decide.sv
module pcf_decide
  import pcf_pkg::*;
#(
  parameter int NUM_SLOTS = 128,
  parameter int IDX_W     = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [CID_W-1:0] cid_i,
  input  logic             sec_i,
  input  logic             priv_i,
  input  slot_cfg_t        cfg_i,
  input  logic             taken_i,
  input  logic [CID_W-1:0] owner_i,
  input  logic             sec_bit_i,
  input  logic             priv_bit_i,
  output logic             grant_o
);
  logic in_range, sem_mode, cid_ok, attr_ok;

  assign in_range = int'(idx_i) < NUM_SLOTS;
  assign sem_mode = cfg_i.fen && cfg_i.sem_en;

  always_comb begin
    if (sem_mode)                          cid_ok = taken_i && owner_i == cid_i && cfg_i.wl[cid_i];
    else if (!cfg_i.fen || cfg_i.scid == '0) cid_ok = 1'b1;
    else                                   cid_ok = cfg_i.scid == cid_i;
  end

  assign attr_ok = !(sec_bit_i && !sec_i) && !(priv_bit_i && !priv_i);
  assign grant_o = in_range && cid_ok && attr_ok;

  // R11
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(idx_i) >= NUM_SLOTS) |-> !grant_o);
  // R10
  attr_deny_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> ((sec_i || !sec_bit_i) && (priv_i || !priv_bit_i)));
  // R7
  sem_holder_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && cfg_i.fen && cfg_i.sem_en) |-> (taken_i && owner_i == cid_i));
endmodule

// File: rtl/periph_access_filter.sv
module periph_access_filter
  import pcf_pkg::*;
#(
  parameter int NUM_SLOTS   = 128,
  parameter int IDX_W       = 7,
  parameter int NUM_MASTERS = 16,
  parameter int NUM_SUBREG  = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             bus_req_i,
  input  logic             bus_we_i,
  input  logic [11:0]      bus_addr_i,
  input  logic [31:0]      bus_wdata_i,
  input  logic [2:0]       bus_cid_i,
  output logic [31:0]      bus_rdata_o,
  input  logic [IDX_W-1:0] chk_idx_i,
  input  logic [2:0]       chk_cid_i,
  input  logic             chk_sec_i,
  input  logic             chk_priv_i,
  output logic             grant_o
);
  localparam int          ADDR_W    = 12;
  localparam int          WSEL_W    = 3;
  localparam logic [11:0] SEC_BASE  = 12'h010;
  localparam logic [11:0] PRIV_BASE = 12'h030;
  localparam logic [11:0] SLOT_BASE = 12'h100;
  localparam logic [11:0] CAP_ADDR  = 12'hFEC;
  localparam logic [31:0] CAP_WORD  = {8'(NUM_SUBREG), 8'(NUM_MASTERS), 16'(NUM_SLOTS)};

  logic              bus_wr, aligned;
  logic              sec_hit, priv_hit, slot_hit, cap_hit;
  logic [ADDR_W-1:0] sec_off, priv_off, slot_off;
  logic [8:0]        sidx;
  logic [IDX_W-1:0]  si;

  assign bus_wr   = bus_req_i && bus_we_i;
  assign aligned  = bus_addr_i[1:0] == 2'b00;
  assign sec_off  = bus_addr_i - SEC_BASE;
  assign priv_off = bus_addr_i - PRIV_BASE;
  assign slot_off = bus_addr_i - SLOT_BASE;
  assign sidx     = slot_off[ADDR_W-1:3];
  assign si       = sidx[IDX_W-1:0];
  assign sec_hit  = aligned && bus_addr_i >= SEC_BASE && bus_addr_i < PRIV_BASE;
  assign priv_hit = aligned && bus_addr_i >= PRIV_BASE && bus_addr_i < PRIV_BASE + 12'h020;
  assign slot_hit = aligned && bus_addr_i >= SLOT_BASE && int'(sidx) < NUM_SLOTS;
  assign cap_hit  = bus_addr_i == CAP_ADDR;

  slot_cfg_t            cfg_a   [NUM_SLOTS];
  logic                 taken_a [NUM_SLOTS];
  logic [CID_W-1:0]     owner_a [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] sec_vec, priv_vec;
  logic [31:0]          sec_rword, priv_rword;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = bus_wr && slot_hit && int'(sidx) == g;
    pcf_slot u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cfg_we_i (hit && !bus_addr_i[2]),
      .sem_we_i (hit && bus_addr_i[2]),
      .wdata_i  (bus_wdata_i),
      .wr_cid_i (bus_cid_i),
      .cfg_o    (cfg_a[g]),
      .taken_o  (taken_a[g]),
      .owner_o  (owner_a[g])
    );
  end

  pcf_attr_bank #(.NUM_SLOTS(NUM_SLOTS), .WSEL_W(WSEL_W)) u_sec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_wr && sec_hit),
    .word_i  (sec_off[4:2]),
    .wdata_i (bus_wdata_i),
    .vec_o   (sec_vec),
    .rword_o (sec_rword)
  );

  pcf_attr_bank #(.NUM_SLOTS(NUM_SLOTS), .WSEL_W(WSEL_W)) u_priv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_wr && priv_hit),
    .word_i  (priv_off[4:2]),
    .wdata_i (bus_wdata_i),
    .vec_o   (priv_vec),
    .rword_o (priv_rword)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (cap_hit)       bus_rdata_o = CAP_WORD;
    else if (sec_hit)  bus_rdata_o = sec_rword;
    else if (priv_hit) bus_rdata_o = priv_rword;
    else if (slot_hit) bus_rdata_o = bus_addr_i[2] ? pack_sem(taken_a[si], owner_a[si])
                                                   : pack_cfg(cfg_a[si]);
  end

  // index clamped so an out-of-range check never reads past the arrays
  logic [IDX_W-1:0] ci;
  assign ci = (int'(chk_idx_i) < NUM_SLOTS) ? chk_idx_i : '0;

  pcf_decide #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_decide (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .idx_i      (chk_idx_i),
    .cid_i      (chk_cid_i),
    .sec_i      (chk_sec_i),
    .priv_i     (chk_priv_i),
    .cfg_i      (cfg_a[ci]),
    .taken_i    (taken_a[ci]),
    .owner_i    (owner_a[ci]),
    .sec_bit_i  (sec_vec[ci]),
    .priv_bit_i (priv_vec[ci]),
    .grant_o    (grant_o)
  );

  // R3
  cap_const_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_hit |-> bus_rdata_o == CAP_WORD);
endmodule

// File: tb/sim_periph_access_filter.sv
module sim_periph_access_filter;
  localparam int NS = 40;
  localparam int NM = 16;
  localparam int NR = 2;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [2:0]  bus_cid_i = '0;
  logic [31:0] bus_rdata_o;
  logic [6:0]  chk_idx_i = '0;
  logic [2:0]  chk_cid_i = '0;
  logic        chk_sec_i = 1'b0, chk_priv_i = 1'b0;
  logic        grant_o;

  int total = 0, bad = 0;
  logic [31:0] m_cfg [NS];
  logic        m_sec [NS], m_priv [NS], m_taken [NS];
  logic [2:0]  m_owner [NS];

  always #10 clk = ~clk;

  periph_access_filter #(.NUM_SLOTS(NS), .IDX_W(7), .NUM_MASTERS(NM), .NUM_SUBREG(NR)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_cid_i(bus_cid_i),
    .bus_rdata_o(bus_rdata_o), .chk_idx_i(chk_idx_i), .chk_cid_i(chk_cid_i),
    .chk_sec_i(chk_sec_i), .chk_priv_i(chk_priv_i), .grant_o(grant_o));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic [2:0] c);
    @(negedge clk);
    bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d; bus_cid_i = c;
    @(negedge clk);
    bus_req_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr_i = a;
    #2 d = bus_rdata_o;
  endtask

  // model of the semaphore write rules (R4, R5, R6)
  task automatic sem_write(int n, logic [31:0] d, logic [2:0] c);
    wr(12'(12'h104 + 8 * n), d, c);
    if (d[0]) begin
      if (!m_taken[n] && m_cfg[n][1] && m_cfg[n][16 + c]) begin
        m_taken[n] = 1'b1; m_owner[n] = c;
      end else if (m_taken[n] && m_owner[n] == c) begin
        m_taken[n] = 1'b0; m_owner[n] = 3'd0;
      end
    end
  endtask

  function automatic logic exp_grant(int idx, int cid, logic s, logic p);
    logic ok;
    logic [31:0] c;
    if (idx >= NS) return 1'b0;
    c = m_cfg[idx];
    if (c[0] && c[1])                  ok = m_taken[idx] && m_owner[idx] == 3'(cid) && c[16 + cid];
    else if (!c[0] || c[6:4] == 3'd0) ok = 1'b1;
    else                               ok = c[6:4] == 3'(cid);
    return ok && !(m_sec[idx] && !s) && !(m_priv[idx] && !p);
  endfunction

  function automatic string grant_tag(int idx, logic s, logic p);
    logic [31:0] c;
    if (idx >= NS) return "R11";
    if ((m_sec[idx] && !s) || (m_priv[idx] && !p)) return "R10";
    c = m_cfg[idx];
    if (c[0] && c[1]) return "R7";
    if (!c[0] || c[6:4] == 3'd0) return "R8";
    return "R9";
  endfunction

  task automatic sweep(bit after_reset);
    for (int i = 0; i < 48; i++)
      for (int c = 0; c < 8; c++)
        for (int a = 0; a < 4; a++) begin
          @(negedge clk);
          chk_idx_i = 7'(i); chk_cid_i = 3'(c); chk_sec_i = a[0]; chk_priv_i = a[1];
          #2;
          check((after_reset && i < NS) ? "R12" : grant_tag(i, a[0], a[1]),
                {31'd0, grant_o}, {31'd0, exp_grant(i, c, a[0], a[1])});
        end
  endtask

  task automatic check_sem_all(string tag);
    logic [31:0] d;
    for (int n = 0; n < NS; n++) begin
      rd(12'(12'h104 + 8 * n), d);
      check(tag, d, {25'd0, m_owner[n], 3'd0, m_taken[n]});
    end
  endtask

  initial begin : watchdog
    #(20 * 150000);
    bad++; total++;
    $display("FAIL R12 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d, raw;
    for (int n = 0; n < NS; n++) begin
      m_cfg[n] = '0; m_sec[n] = 0; m_priv[n] = 0; m_taken[n] = 0; m_owner[n] = '0;
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R12 reset state
    rd(12'h100, d);            check("R12", d, 32'h0);
    rd(12'h104 + 8 * 39, d);   check("R12", d, 32'h0);
    rd(12'h010, d);            check("R12", d, 32'h0);
    rd(12'h034, d);            check("R12", d, 32'h0);
    sweep(1'b1);

    // R3 capability word, read-only
    rd(12'hFEC, d);            check("R3", d, {8'(NR), 8'(NM), 16'(NS)});
    wr(12'hFEC, 32'h0, 3'd1);
    rd(12'hFEC, d);            check("R3", d, {8'(NR), 8'(NM), 16'(NS)});

    // R1 configuration with reserved-bit noise
    for (int n = 0; n < NS; n++) begin
      raw = 32'hFF00_FF8C;
      raw[0] = (n % 3) != 0;
      raw[1] = n[0];
      raw[6:4] = 3'(n);
      raw[23:16] = (8'd1 << ((n + 1) % 8)) | 8'(n * 29);
      wr(12'(12'h100 + 8 * n), raw, 3'd2);
      m_cfg[n] = raw & 32'h00FF_0073;
    end
    for (int n = 0; n < NS; n++) begin
      rd(12'(12'h100 + 8 * n), d);
      check("R1", d, m_cfg[n]);
    end

    // R2 packed secure / privileged vectors
    wr(12'h010, 32'hA5A5_0F0F, 3'd0);
    wr(12'h014, 32'hFFFF_FFFF, 3'd0);
    wr(12'h030, 32'h3C3C_5A5A, 3'd0);
    wr(12'h034, 32'hFFFF_FFAA, 3'd0);
    wr(12'h018, 32'hFFFF_FFFF, 3'd0);
    for (int n = 0; n < NS; n++) begin
      m_sec[n]  = (n < 32) ? 32'hA5A5_0F0F >> n & 1 : 1'b1;
      m_priv[n] = (n < 32) ? 32'h3C3C_5A5A >> n & 1 : 32'hAA >> (n - 32) & 1;
    end
    rd(12'h010, d); check("R2", d, 32'hA5A5_0F0F);
    rd(12'h014, d); check("R2", d, 32'h0000_00FF);
    rd(12'h034, d); check("R2", d, 32'h0000_00AA);
    rd(12'h018, d); check("R2", d, 32'h0);

    // R4 / R5 takes from assorted compartments
    for (int n = 0; n < NS; n++) sem_write(n, 32'h1, 3'((n * 5) % 8));
    check_sem_all("R4");
    // R5: bit 0 clear from anyone has no effect
    for (int n = 0; n < NS; n++) sem_write(n, 32'hFFFF_FFFE, m_owner[n]);
    check_sem_all("R5");
    // R6: release attempt from a non-owner
    for (int n = 0; n < NS; n++) if (m_taken[n]) sem_write(n, 32'h1, m_owner[n] + 3'd1);
    check_sem_all("R6");
    sweep(1'b0);

    // R6: owner releases, then a different compartment retakes
    for (int n = 0; n < NS; n++)
      if (m_taken[n]) begin
        logic [2:0] o;
        o = m_owner[n];
        sem_write(n, 32'h1, o);
        rd(12'(12'h104 + 8 * n), d); check("R6", d, 32'h0);
        for (int k = 1; k < 8; k++) sem_write(n, 32'h1, o + 3'(k));
      end
    check_sem_all("R6");
    sweep(1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule